// File: doc/BRIEF.md
# Host Frame Timer and Start-of-Frame Scheduler

This block sits on the host side of a serial bus controller and sets the bus's time base. It counts ticks of its reference clock and raises a one-cycle start-of-frame request at each frame boundary. In full-speed mode that is once per millisecond. In high-speed mode it is once per 125 µs microframe, eight times per millisecond. With each request it presents the 11-bit frame number that the packet builder places in the start-of-frame packet. In high-speed mode it also presents the index of the current microframe.

Ports that run at low speed get no start-of-frame traffic. For them the block raises a separate keep-alive request once per millisecond, in both modes. It also drives a level output that stays high for a parameterised number of clock cycles, which is the width of the single-ended-zero pulse (about 1.33 µs). An enable input pauses the timer and keeps all of its counts. A synchronous reset clears the counts to zero. The block does not build or serialise the packet, and it does not compute the packet's CRC.

Top module: `sof_frame_timer`

## Requirements
- R1: While reset is high, and in the first cycle after a reset edge, frame_num and uframe_idx are 0, and sof_req, ka_req and ka_se0 are all low.
- R2: With hs_mode low (full speed), sof_req is high after every TICKS_PER_MS-th enabled clock edge counted since reset, and at no other time.
- R3: With hs_mode high (high speed), sof_req is high after every (TICKS_PER_MS/8)-th enabled clock edge counted since reset.
- R4: frame_num rises by one only at a millisecond boundary, in the same cycle as ka_req. In high-speed mode the same frame_num is therefore carried by eight consecutive start-of-frame requests.
- R5: frame_num is 11 bits wide and steps from 2047 to 0.
- R6: In high-speed mode, uframe_idx equals (enabled edges since reset / (TICKS_PER_MS/8)) mod 8. In full-speed mode it reads 0.
- R7: ka_req is high after every TICKS_PER_MS-th enabled edge in both modes, and always together with sof_req.
- R8: ka_se0 rises in the same cycle as ka_req and stays high for exactly KA_LEN cycles, whether or not en is high.
- R9: When en is low at a clock edge, no counter advances. After that edge frame_num is unchanged and sof_req and ka_req are low.
- R10: sof_req and ka_req are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Timer run enable; when low, all counts are held |
| hs_mode | input | 1 | 1 selects high-speed microframes, 0 selects full-speed frames |
| sof_req | output | 1 | One-cycle start-of-frame request |
| ka_req | output | 1 | One-cycle low-speed keep-alive request |
| ka_se0 | output | 1 | High for KA_LEN cycles during the keep-alive pulse |
| frame_num | output | 11 | Frame number to place in the start-of-frame packet |
| uframe_idx | output | 3 | Microframe index within the frame (0 in full speed) |

## Verification
The assertions check on every cycle the properties that hold locally:
- both strobes are one cycle wide;
- a keep-alive always coincides with a start-of-frame request and starts the single-ended-zero pulse;
- the frame number changes only at a keep-alive and only by one modulo 2048;
- the microframe index reads zero in full-speed mode;
- a disabled edge freezes the frame number and produces no request.

The exact periods between requests, the eight-fold repetition of a frame number in high-speed mode, the 2047-to-0 wrap, the exact pulse length, and the effect of switching modes or pausing partway through a frame can only be shown by the bench's long scenarios. The bench compares these against counts it computes from the number of enabled edges.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int FRAME_W      = 11;
    localparam int UF_PER_FRAME = 8;
    localparam int UF_W         = $clog2(UF_PER_FRAME);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [UF_W-1:0]    uframe_t;

    typedef enum logic {
        SPD_FULL = 1'b0,
        SPD_HIGH = 1'b1
    } speed_e;

    typedef struct packed {
        logic sof;
        logic ka;
    } strobe_t;

    function automatic frame_t frame_advance(input frame_t f);
        return f + frame_t'(1);
    endfunction

    function automatic logic uframe_is_last(input uframe_t u);
        return u == uframe_t'(UF_PER_FRAME - 1);
    endfunction

endpackage

// File: rtl/sft_tick_div.sv
module sft_tick_div #(
    parameter int PERIOD = 7500
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic period_end
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign period_end = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sft_frame_seq.sv
module sft_frame_seq
    import sft_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    uf_step,
    output logic    ms_edge,
    output uframe_t sub_idx,
    output frame_t  frame_q
);
    assign ms_edge = uf_step && uframe_is_last(sub_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_idx <= '0;
            frame_q <= '0;
        end else if (uf_step) begin
            sub_idx <= sub_idx + uframe_t'(1);
            if (uframe_is_last(sub_idx)) begin
                frame_q <= frame_advance(frame_q);
            end
        end
    end
endmodule

// File: rtl/sft_keepalive.sv
module sft_keepalive #(
    parameter int LEN = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic se0
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] remain;

    assign se0 = (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (fire) begin
            remain <= CW'(LEN);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end
endmodule

// File: rtl/sof_frame_timer.sv
module sof_frame_timer
    import sft_pkg::*;
#(
    parameter int TICKS_PER_MS = 60000,
    parameter int KA_LEN       = 80
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        hs_mode,
    output logic        sof_req,
    output logic        ka_req,
    output logic        ka_se0,
    output logic [10:0] frame_num,
    output logic [2:0]  uframe_idx
);
    localparam int UF_TICKS = TICKS_PER_MS / UF_PER_FRAME;

    speed_e  speed;
    logic    uf_step;
    logic    ms_edge;
    uframe_t sub_idx;
    frame_t  frame_q;
    strobe_t strobe_q;

    assign speed = speed_e'(hs_mode);

    sft_tick_div #(.PERIOD(UF_TICKS)) u_div (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .period_end (uf_step)
    );

    sft_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .uf_step (uf_step),
        .ms_edge (ms_edge),
        .sub_idx (sub_idx),
        .frame_q (frame_q)
    );

    sft_keepalive #(.LEN(KA_LEN)) u_ka (
        .clk  (clk),
        .rst  (rst),
        .fire (ms_edge),
        .se0  (ka_se0)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= '0;
        end else begin
            strobe_q.sof <= uf_step && ((speed == SPD_HIGH) || ms_edge);
            strobe_q.ka  <= ms_edge;
        end
    end

    assign sof_req    = strobe_q.sof;
    assign ka_req     = strobe_q.ka;
    assign frame_num  = frame_q;
    assign uframe_idx = (speed == SPD_HIGH) ? sub_idx : '0;
endmodule

// File: rtl/sof_frame_timer_chk.sv
module sof_frame_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        hs_mode,
    input logic        sof_req,
    input logic        ka_req,
    input logic        ka_se0,
    input logic [10:0] frame_num,
    input logic [2:0]  uframe_idx
);
    AST_SOF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sof_req |=> !sof_req); // R10

    AST_KA_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ka_req |=> !ka_req); // R10

    AST_KA_WITH_SOF: assert property (@(posedge clk) disable iff (rst)
        ka_req |-> sof_req); // R7

    AST_KA_STARTS_SE0: assert property (@(posedge clk) disable iff (rst)
        ka_req |-> ka_se0); // R8

    AST_FS_UFRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        !hs_mode |-> (uframe_idx == 3'd0)); // R6

    AST_FRAME_ONLY_AT_MS: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_num) |-> ka_req); // R4

    AST_FRAME_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        ka_req |-> (frame_num == 11'($past(frame_num) + 11'd1))); // R5

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(frame_num) && !sof_req && !ka_req)); // R9
endmodule

bind sof_frame_timer sof_frame_timer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .hs_mode    (hs_mode),
    .sof_req    (sof_req),
    .ka_req     (ka_req),
    .ka_se0     (ka_se0),
    .frame_num  (frame_num),
    .uframe_idx (uframe_idx)
);

// File: tb/sof_frame_timer_test.sv
`timescale 1ns/1ps
module sof_frame_timer_test;
    localparam int TPM = 16;
    localparam int UF  = TPM / 8;
    localparam int KAL = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        hs_mode = 1'b0;
    logic        sof_req, ka_req, ka_se0;
    logic [10:0] frame_num;
    logic [2:0]  uframe_idx;

    int n_checks = 0;
    int n_fail = 0;
    int e = 0;
    int since = 0;
    bit ka_act = 1'b0;
    bit x_sof = 1'b0, x_ka = 1'b0;
    bit saw_wrap = 1'b0;
    int prev_frame = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sof_frame_timer #(.TICKS_PER_MS(TPM), .KA_LEN(KAL)) uut (
        .clk(clk), .rst(rst), .en(en), .hs_mode(hs_mode),
        .sof_req(sof_req), .ka_req(ka_req), .ka_se0(ka_se0),
        .frame_num(frame_num), .uframe_idx(uframe_idx)
    );

    // bench model, updated from the inputs held stable across the edge
    always @(posedge clk) begin
        if (rst) begin
            e = 0; ka_act = 1'b0; since = 0; x_sof = 1'b0; x_ka = 1'b0;
        end else begin
            if (en) begin
                e = e + 1;
                x_ka  = (e % TPM) == 0;
                x_sof = ((e % UF) == 0) && (hs_mode || x_ka);
            end else begin
                x_ka = 1'b0; x_sof = 1'b0;
            end
            if (x_ka) begin
                ka_act = 1'b1; since = 0;
            end else if (ka_act) begin
                since = since + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        int xf, xu;
        bit xs;
        xf = (e / TPM) % 2048;
        xu = hs_mode ? (e / UF) % 8 : 0;
        xs = ka_act && (since < KAL);
        check(sof_req == x_sof, hs_mode ? "R3 sof_req" : "R2 sof_req", sof_req, x_sof);
        check(ka_req == x_ka, "R7 ka_req", ka_req, x_ka);
        check(ka_se0 == xs, "R8 ka_se0", ka_se0, xs);
        check(int'(frame_num) == xf, "R4 frame_num", frame_num, xf);
        check(int'(uframe_idx) == xu, "R6 uframe_idx", uframe_idx, xu);
        if (prev_frame == 2047 && frame_num == 11'd0) saw_wrap = 1'b1;
        prev_frame = frame_num;
    endtask

    task automatic run(input int n, input bit r, input bit en_v, input bit hs_v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
            rst = r; en = en_v; hs_mode = hs_v;
        end
    endtask

    initial begin
        run(3, 1'b1, 1'b0, 1'b0);
        // R1: state right after reset
        @(negedge clk);
        check(frame_num == 11'd0 && uframe_idx == 3'd0, "R1 counts zero", frame_num, 0);
        check(!sof_req && !ka_req && !ka_se0, "R1 strobes low", {sof_req, ka_req, ka_se0}, 0);
        rst = 1'b0; en = 1'b1; hs_mode = 1'b0;
        run(60, 1'b0, 1'b1, 1'b0);      // R2 full speed
        run(70, 1'b0, 1'b1, 1'b1);      // R3 R6 high speed
        run(9, 1'b0, 1'b0, 1'b1);       // R9 paused mid-frame
        run(5, 1'b0, 1'b1, 1'b1);
        run(7, 1'b0, 1'b0, 1'b0);       // R9 paused, mode flips
        for (int k = 0; k < 40; k++) begin
            run(1 + (k % 5), 1'b0, 1'b1, k[2]);
            run(1 + (k % 3), 1'b0, 1'b0, k[2]);
        end
        run(2048 * TPM + 40, 1'b0, 1'b1, 1'b1); // R5 wrap
        check(saw_wrap, "R5 wrap 2047->0 seen", saw_wrap, 1);
        run(2, 1'b1, 1'b1, 1'b1);       // R1 reset mid-run
        run(50, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check_all();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule